// File: doc/BRIEF.md
# Grouped interrupt status aggregator

This block gathers one-cycle event pulses from a DMA engine into a sticky status register and drives one level-sensitive interrupt line. Each event bit has an enable bit. Enabled events are combined into two summary bits, one for the normal group and one for the abnormal group. Both summary bits are registered. The interrupt line is a registered OR of the two summary bits and of the enabled MAC-side sources.

Software reads the status word and clears event bits by writing ones. Interrupts are not queued. A bit that is already set absorbs any further events of the same kind. The line stays high as long as any enabled bit in either group is still pending.

The MAC-side sources are levels. They appear in the status word as they are and are never latched. A bus error response sets the fatal bus error bit, records an error type and halts the DMA. Only a reset or the soft-reset input releases that halt.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word, the enable register, `dma_halt_o` and `irq_o` are all zero.
- R2: An event pulse on `ev_i[k]` sets status bit k at the next clock edge whether or not it is enabled, and the bit stays set until it is cleared.
- R3: When `clr_we_i` is high, each 1 in `clr_data_i[k]` clears status bit k at the next edge. Zero bits leave the status unchanged.
- R4: If an event and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R5: Status bit 8 (normal summary) becomes, one cycle after the event bits, the OR of the enabled event bits 0, 3, 5 and 6. Bit 6 is receive-done. Status bit 9 (abnormal summary) is the same for bits 1, 2, 4 and 7. Bit 7 is receive-buffer-unavailable and bit 4 is fatal bus error.
- R6: `irq_o` becomes, one cycle later, the OR of both summary bits and of every MAC source that is enabled in `en_data` bits 12:8. Clearing bit 6 therefore leaves `irq_o` high while bit 7 is still set and enabled.
- R7: An event whose enable bit is 0 never raises `irq_o`, even though its status bit is set.
- R8: Status bits 14:10 show `mac_i` in the same cycle without latching. Removing a MAC source therefore drops its bit at once and drops `irq_o` one cycle later.
- R9: `bus_err_i` sets status bit 4, stores `bus_err_type_i` in status bits 17:15 and raises `dma_halt_o`. Clearing bit 4 does not lower the halt.
- R10: `soft_rst_i` clears the event bits, the summary bits, the error type, `dma_halt_o` and `irq_o` at the next edge. It overrides events in the same cycle and leaves the enable register untouched.
- R11: `ev_i[4]` has no effect. Only `bus_err_i` can set status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| ev_i | input | 8 | DMA event pulses, one per status bit |
| mac_i | input | 5 | MAC-side level interrupt sources |
| bus_err_i | input | 1 | Bus error response pulse |
| bus_err_type_i | input | 3 | Error type recorded with a bus error |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | 8 | Bits to clear in the event field |
| en_we_i | input | 1 | Enable register write strobe |
| en_data_i | input | 13 | Enable value: 7:0 events, 12:8 MAC sources |
| status_o | output | 18 | Event bits, summaries, MAC levels, error type |
| enable_o | output | 13 | Current enable register |
| dma_halt_o | output | 1 | DMA halted after a bus error |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two things can fall in the same cycle: an incoming event and a software clear of the same bit, and a soft reset and a new event. The bench provokes both by driving the event pulse and the clear strobe (or the soft reset) in the same cycle. It then reads the status word on the following cycle and expects the bit to be set in the first case and clear in the second. A sweep over all 256 enable patterns, each with a derived event and clear pattern, checks the status, both summaries and the interrupt line at their expected latencies against values computed in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int EVW      = 8;
  localparam int MACW     = 5;
  localparam int ETW      = 3;
  localparam int FBE_POS  = 4;
  localparam int NSUM_POS = EVW;
  localparam int ASUM_POS = EVW + 1;
  localparam int MAC_LO   = EVW + 2;
  localparam int ET_LO    = MAC_LO + MACW;
  localparam int STW      = ET_LO + ETW;
  localparam int ENW      = EVW + MACW;
  localparam int NGRP     = 2;

  localparam logic [EVW-1:0] NORM_GRP = 8'b0110_1001;
  localparam logic [EVW-1:0] ABN_GRP  = 8'b1001_0110;

  function automatic logic grp_hit(input logic [EVW-1:0] st,
                                   input logic [EVW-1:0] en,
                                   input logic [EVW-1:0] grp);
    return |(st & en & grp);
  endfunction

  function automatic logic [EVW-1:0] next_sticky(input logic [EVW-1:0] st,
                                                 input logic [EVW-1:0] set,
                                                 input logic [EVW-1:0] clr);
    return set | (st & ~clr);
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst_i,
  input  logic [EVW-1:0] set_i,
  input  logic [EVW-1:0] clr_i,
  output logic [EVW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_o <= '0;
    else if (soft_rst_i) q_o <= '0;
    else                 q_o <= next_sticky(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/irq_group_summary.sv
module irq_group_summary
  import irq_agg_pkg::*;
#(
  parameter logic [EVW-1:0] GRP = NORM_GRP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst_i,
  input  logic [EVW-1:0] st_i,
  input  logic [EVW-1:0] en_i,
  output logic           sum_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sum_o <= 1'b0;
    else if (soft_rst_i) sum_o <= 1'b0;
    else                 sum_o <= grp_hit(st_i, en_i, GRP);
  end
endmodule

// File: rtl/irq_fatal_latch.sv
module irq_fatal_latch
  import irq_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst_i,
  input  logic           err_i,
  input  logic [ETW-1:0] type_i,
  output logic           halt_o,
  output logic [ETW-1:0] type_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_o <= 1'b0;
      type_o <= '0;
    end else if (soft_rst_i) begin
      halt_o <= 1'b0;
      type_o <= '0;
    end else if (err_i) begin
      halt_o <= 1'b1;
      type_o <= type_i;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst_i,
  input  logic [EVW-1:0]  ev_i,
  input  logic [MACW-1:0] mac_i,
  input  logic            bus_err_i,
  input  logic [ETW-1:0]  bus_err_type_i,
  input  logic            clr_we_i,
  input  logic [EVW-1:0]  clr_data_i,
  input  logic            en_we_i,
  input  logic [ENW-1:0]  en_data_i,
  output logic [STW-1:0]  status_o,
  output logic [ENW-1:0]  enable_o,
  output logic            dma_halt_o,
  output logic            irq_o
);
  localparam logic [EVW-1:0] GRP_MASKS [NGRP] = '{NORM_GRP, ABN_GRP};

  // Named internal events, brought out for the checker
  logic [EVW-1:0]  set_vec;
  logic [EVW-1:0]  clr_vec;
  logic [EVW-1:0]  ev_st;
  logic [NGRP-1:0] sum_q;
  logic [ENW-1:0]  en_q;
  logic [ETW-1:0]  et_q;
  logic            mac_hit;

  always_comb begin
    set_vec          = ev_i;
    set_vec[FBE_POS] = bus_err_i;
    clr_vec          = clr_we_i ? clr_data_i : '0;
  end

  irq_sticky_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .q_o        (ev_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_data_i;
  end

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    irq_group_summary #(.GRP(GRP_MASKS[gi])) u_sum (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst_i),
      .st_i       (ev_st),
      .en_i       (en_q[EVW-1:0]),
      .sum_o      (sum_q[gi])
    );
  end

  irq_fatal_latch u_fatal (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .err_i      (bus_err_i),
    .type_i     (bus_err_type_i),
    .halt_o     (dma_halt_o),
    .type_o     (et_q)
  );

  assign mac_hit = |(mac_i & en_q[ENW-1:EVW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_o <= 1'b0;
    else if (soft_rst_i) irq_o <= 1'b0;
    else                 irq_o <= (|sum_q) | mac_hit;
  end

  assign status_o = {et_q, mac_i, sum_q[1], sum_q[0], ev_st};
  assign enable_o = en_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst_i,
  input logic [MACW-1:0] mac_i,
  input logic [EVW-1:0]  set_vec,
  input logic [EVW-1:0]  clr_vec,
  input logic [STW-1:0]  status_o,
  input logic [ENW-1:0]  enable_o,
  input logic            dma_halt_o,
  input logic            irq_o
);
  // R4: an event in the same cycle as a clear leaves the bit set
  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> ((status_o[EVW-1:0] & $past(set_vec)) == $past(set_vec)));

  // R2: set bits that were not cleared stay set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> ((status_o[EVW-1:0] & $past(status_o[EVW-1:0] & ~clr_vec))
                     == $past(status_o[EVW-1:0] & ~clr_vec)));

  // R5: normal summary follows enabled normal-group bits by one cycle
  p_nsum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> (status_o[NSUM_POS] ==
                     $past(grp_hit(status_o[EVW-1:0], enable_o[EVW-1:0], NORM_GRP))));

  // R5: abnormal summary follows enabled abnormal-group bits by one cycle
  p_asum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> (status_o[ASUM_POS] ==
                     $past(grp_hit(status_o[EVW-1:0], enable_o[EVW-1:0], ABN_GRP))));

  // R6: interrupt line is one cycle behind summaries and enabled MAC levels
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> (irq_o == $past(status_o[NSUM_POS] | status_o[ASUM_POS] |
                                    (|(mac_i & enable_o[ENW-1:EVW])))));

  // R9: halt persists until a soft reset
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_halt_o && !soft_rst_i) |=> dma_halt_o);

  // R10: soft reset clears summaries, halt and the line
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!irq_o && !dma_halt_o && status_o[ASUM_POS:0] == '0));
endmodule

bind irq_aggregator irq_agg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst_i (soft_rst_i),
  .mac_i      (mac_i),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec),
  .status_o   (status_o),
  .enable_o   (enable_o),
  .dma_halt_o (dma_halt_o),
  .irq_o      (irq_o)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [7:0]  ev_i = '0;
  logic [4:0]  mac_i = '0;
  logic        bus_err_i = 1'b0;
  logic [2:0]  bus_err_type_i = '0;
  logic        clr_we_i = 1'b0;
  logic [7:0]  clr_data_i = '0;
  logic        en_we_i = 1'b0;
  logic [12:0] en_data_i = '0;
  logic [17:0] status_o;
  logic [12:0] enable_o;
  logic        dma_halt_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_aggregator i_irq_aggregator (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic nexp(input logic [7:0] st, input logic [7:0] en);
    return (st[0] & en[0]) | (st[3] & en[3]) | (st[5] & en[5]) | (st[6] & en[6]);
  endfunction

  function automatic logic aexp(input logic [7:0] st, input logic [7:0] en);
    return (st[1] & en[1]) | (st[2] & en[2]) | (st[4] & en[4]) | (st[7] & en[7]);
  endfunction

  initial begin
    #500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    step();
    chk("R1 enable", enable_o, 0);
    chk("R1 halt", dma_halt_o, 0);

    // Sweep: every enable pattern with a derived event and clear pattern
    for (int a = 0; a < 256; a++) begin
      logic [7:0] en, ev, eff, cl, rem;
      en  = a[7:0];
      ev  = 8'((a * 37 + 11) & 255);
      cl  = 8'((a * 91 + 5) & 255);
      eff = ev & 8'hEF;
      rem = eff & ~cl;
      soft_rst_i = 1'b1; en_we_i = 1'b1; en_data_i = {5'b0, en};
      step();
      soft_rst_i = 1'b0; en_we_i = 1'b0; ev_i = ev;
      step();
      ev_i = '0;
      chk("R2/R11 sweep status", status_o[7:0], eff);
      step();
      chk("R5 sweep nsum", status_o[8], nexp(eff, en));
      chk("R5 sweep asum", status_o[9], aexp(eff, en));
      step();
      chk("R6/R7 sweep irq", irq_o, nexp(eff, en) | aexp(eff, en));
      clr_we_i = 1'b1; clr_data_i = cl;
      step();
      clr_we_i = 1'b0;
      chk("R3 sweep clear", status_o[7:0], rem);
      step(); step();
      chk("R6 sweep irq after clear", irq_o, nexp(rem, en) | aexp(rem, en));
    end

    // R4: event and clear of bit 6 in the same cycle
    soft_rst_i = 1'b1; en_we_i = 1'b1; en_data_i = 13'h0C0;
    step();
    soft_rst_i = 1'b0; en_we_i = 1'b0;
    ev_i = 8'h40; clr_we_i = 1'b1; clr_data_i = 8'h40;
    step();
    ev_i = '0; clr_we_i = 1'b0;
    chk("R4 event beats clear", status_o[6], 1);

    // R6: RBU keeps the line up after RI is cleared
    ev_i = 8'h80;
    step();
    ev_i = '0;
    step(); step();
    chk("R6 irq with RI and RBU", irq_o, 1);
    clr_we_i = 1'b1; clr_data_i = 8'h40;
    step();
    clr_we_i = 1'b0;
    step(); step();
    chk("R6 irq held by RBU", irq_o, 1);
    clr_we_i = 1'b1; clr_data_i = 8'h80;
    step();
    clr_we_i = 1'b0;
    step(); step();
    chk("R6 irq low after RBU clear", irq_o, 0);

    // R8: MAC levels pass through live
    en_we_i = 1'b1; en_data_i = 13'h0400;
    step();
    en_we_i = 1'b0;
    mac_i = 5'b00100;
    #1;
    chk("R8 mac visible", status_o[14:10], 5'b00100);
    step();
    chk("R8 enabled mac raises irq", irq_o, 1);
    mac_i = 5'b00010;
    #1;
    chk("R8 mac not latched", status_o[14:10], 5'b00010);
    step();
    chk("R7 disabled mac no irq", irq_o, 0);
    mac_i = '0;

    // R11: ev_i[4] alone does nothing
    ev_i = 8'h10;
    step();
    ev_i = '0;
    chk("R11 ev4 ignored", status_o[4], 0);

    // R9: bus error
    en_we_i = 1'b1; en_data_i = 13'h0010;
    bus_err_i = 1'b1; bus_err_type_i = 3'b101;
    step();
    en_we_i = 1'b0; bus_err_i = 1'b0; bus_err_type_i = '0;
    chk("R9 fbe set", status_o[4], 1);
    chk("R9 error type", status_o[17:15], 3'b101);
    chk("R9 halt", dma_halt_o, 1);
    step(); step();
    chk("R9 fbe raises irq", irq_o, 1);
    clr_we_i = 1'b1; clr_data_i = 8'h10;
    step();
    clr_we_i = 1'b0;
    chk("R9 fbe cleared", status_o[4], 0);
    chk("R9 halt held", dma_halt_o, 1);

    // R10: soft reset beats a same-cycle event; enables kept
    soft_rst_i = 1'b1; ev_i = 8'h41;
    step();
    soft_rst_i = 1'b0; ev_i = '0;
    chk("R10 status cleared", status_o, 0);
    chk("R10 halt cleared", dma_halt_o, 0);
    chk("R10 irq cleared", irq_o, 0);
    chk("R10 enable kept", enable_o, 13'h0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule